// File: doc/BRIEF.md
# Power Stage Fault Retry Controller

This block watches the fault flag of a power output stage and runs an automatic recovery sequence when the flag shows trouble. The fault flag is active low and covers over-current and thermal events. When the block sees a fault, it drives an active-low recovery command to the stage for a fixed window (1 ms at a 49.152 MHz clock, which is 49,152 cycles). It then releases the command for one cycle and checks the fault again. While the fault remains, the block keeps issuing these pulses of the same fixed length.

The same fault is reported on an active-low interrupt line. That line follows the synchronized fault and is released on the first clock after the fault clears. A bypass input suppresses the recovery pulses but still lets the interrupt line report the fault. The pulse length is a cycle-count parameter, so the block can be simulated with a short window.

Top module: `fault_retry_ctrl`

## Requirements
- R1: While reset is asserted, `recover_n_o` and `irq_n_o` are both 1.
- R2: `irq_n_o` equals the value `fault_n_i` had three rising clock edges earlier, with bypass having no effect. One edge is the output register and two are the synchronizer.
- R3: With bypass low and no pulse in progress, `recover_n_o` goes to 0 on the same edge on which `irq_n_o` first reports a fault.
- R4: Each recovery pulse that bypass does not abort holds `recover_n_o` at 0 for exactly PULSE_CYCLES clock cycles.
- R5: After a pulse ends, `recover_n_o` stays at 1 for exactly one cycle and then returns to 0 if the synchronized fault is still present and bypass is low.
- R6: If the synchronized fault has cleared by the end of a pulse, `recover_n_o` stays at 1 and no new pulse starts until a new fault arrives.
- R7: A fault that clears in the middle of a pulse does not shorten that pulse.
- R8: When `bypass_i` is 1 at a clock edge, `recover_n_o` is 1 after that edge. This holds whether or not a fault is present and aborts any pulse in progress.
- R9: When bypass drops while the synchronized fault is present, a pulse starts on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_n_i | input | 1 | Power stage fault flag, 0 = fault (asynchronous) |
| bypass_i | input | 1 | 1 = suppress recovery pulses |
| recover_n_o | output | 1 | Recovery command to the power stage, 0 = recover |
| irq_n_o | output | 1 | Fault interrupt, 0 = fault present |

## Verification
The hardest case to reach is the boundary between a finished pulse and the next re-test. The fault must either persist through the single high cycle or vanish exactly inside a pulse, and only certain input timings produce each outcome.

The directed part of the stimulus holds the fault across a complete pulse so that the one-cycle gap can be measured. It then clears the fault in the middle of the second pulse to show that the pulse runs to full length and that no further pulse follows. The random phase toggles the fault and the bypass with short hold times under a fixed seed, with the window shortened to 40 cycles. This lands many transitions close to pulse ends and bypass aborts. A cycle-accurate reference model computed in the bench checks every cycle.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_CHECK = 2'd2
    } fr_state_e;

    typedef struct packed {
        fr_state_e state;
        logic      rec_n;
        logic      irq_n;
    } fr_regs_t;

endpackage

// File: rtl/fr_sync.sv
module fr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fr_timer.sv
module fr_timer #(
    parameter int CYCLES = 49152
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done_o = run_i && (cnt_q == LAST);

    always_comb begin
        if (run_i && !done_o) cnt_d = cnt_q + 1'b1;
        else                  cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fr_fsm.sv
module fr_fsm
    import fr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic bypass_i,
    input  logic done_i,
    output logic run_o,
    output logic rec_n_o,
    output logic irq_n_o
);
    localparam fr_regs_t RESET_VAL = '{state: ST_IDLE, rec_n: 1'b1, irq_n: 1'b1};

    fr_regs_t regs_d, regs_q;
    logic     want_retry;

    assign want_retry = fault_i && !bypass_i;

    always_comb begin
        regs_d       = regs_q;
        regs_d.irq_n = ~fault_i;
        unique case (regs_q.state)
            ST_IDLE: begin
                regs_d.rec_n = 1'b1;
                if (want_retry) begin
                    regs_d.state = ST_PULSE;
                    regs_d.rec_n = 1'b0;
                end
            end
            ST_PULSE: begin
                if (bypass_i) begin
                    regs_d.state = ST_IDLE;
                    regs_d.rec_n = 1'b1;
                end else if (done_i) begin
                    regs_d.state = ST_CHECK;
                    regs_d.rec_n = 1'b1;
                end
            end
            ST_CHECK: begin
                if (want_retry) begin
                    regs_d.state = ST_PULSE;
                    regs_d.rec_n = 1'b0;
                end else begin
                    regs_d.state = ST_IDLE;
                    regs_d.rec_n = 1'b1;
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
                regs_d.rec_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RESET_VAL;
        else        regs_q <= regs_d;
    end

    assign run_o   = (regs_q.state == ST_PULSE);
    assign rec_n_o = regs_q.rec_n;
    assign irq_n_o = regs_q.irq_n;
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl #(
    parameter int PULSE_CYCLES = 49152,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n_i,
    input  logic bypass_i,
    output logic recover_n_o,
    output logic irq_n_o
);
    logic fault_n_sync;
    logic pulse_run;
    logic pulse_done;

    fr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fault_n_i),
        .sync_o  (fault_n_sync)
    );

    fr_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (pulse_run),
        .done_o (pulse_done)
    );

    fr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (~fault_n_sync),
        .bypass_i (bypass_i),
        .done_i   (pulse_done),
        .run_o    (pulse_run),
        .rec_n_o  (recover_n_o),
        .irq_n_o  (irq_n_o)
    );
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
    parameter int PULSE_CYCLES = 49152
) (
    input logic clk,
    input logic rst_n,
    input logic fault_n_i,
    input logic bypass_i,
    input logic recover_n_o,
    input logic irq_n_o
);
    localparam int LW = $clog2(PULSE_CYCLES + 2) + 1;
    localparam logic [LW-1:0] FULL = LW'(PULSE_CYCLES);

    logic [1:0]    age_q;
    logic [LW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
            low_q <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 1'b1;
            if (recover_n_o)         low_q <= '0;
            else if (low_q != '1)    low_q <= low_q + 1'b1;
        end
    end

    // R1: reset drives both outputs high
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (recover_n_o && irq_n_o);
        end
    end

    assert_irq_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (irq_n_o == $past(fault_n_i, 3)));

    assert_start_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recover_n_o) |-> !irq_n_o);

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (recover_n_o && $past(!recover_n_o) && !$past(bypass_i)) |-> (low_q == FULL));

    assert_pulse_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !recover_n_o |-> (low_q < FULL));

    assert_bypass_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |=> recover_n_o);
endmodule

bind fault_retry_ctrl fr_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_fr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_n_i   (fault_n_i),
    .bypass_i    (bypass_i),
    .recover_n_o (recover_n_o),
    .irq_n_o     (irq_n_o)
);

// File: tb/fault_retry_ctrl_test.sv
module fault_retry_ctrl_test;
    localparam int N = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault_n = 1'b1;
    logic bypass = 1'b0;
    logic rec_n;
    logic irq_n;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  cmp_en = 1'b0;

    always #10 clk = ~clk;

    fault_retry_ctrl #(.PULSE_CYCLES(N)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_n_i   (fault_n),
        .bypass_i    (bypass),
        .recover_n_o (rec_n),
        .irq_n_o     (irq_n)
    );

    // reference model built from the requirements
    logic [2:0] m_pipe;
    logic       m_rec;
    logic       m_irq;
    int         m_low;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pipe <= 3'b111;
            m_rec  <= 1'b1;
            m_irq  <= 1'b1;
            m_low  <= 0;
        end else begin
            m_pipe <= {m_pipe[1:0], fault_n};
            m_irq  <= m_pipe[1];
            if (bypass) begin
                m_rec <= 1'b1;
                m_low <= 0;
            end else if (!m_rec) begin
                if (m_low == N - 1) begin
                    m_rec <= 1'b1;
                    m_low <= 0;
                end else begin
                    m_low <= m_low + 1;
                end
            end else if (!m_pipe[1]) begin
                m_rec <= 1'b0;
                m_low <= 0;
            end
        end
    end

    function automatic string rec_tag(logic byp, logic exp_rec);
        if (byp)      return "R8";
        if (!exp_rec) return "R4";
        return "R6";
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            check("R2", irq_n, m_irq);
            check(rec_tag(bypass, m_rec), rec_n, m_rec);
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int len;
        void'($urandom(32'd20240611));

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", rec_n, 1'b1);
        check("R1", irq_n, 1'b1);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);

        // R2/R3 detection latency
        fault_n = 1'b0;
        @(negedge clk);
        check("R2", irq_n, 1'b1);
        @(negedge clk);
        check("R2", irq_n, 1'b1);
        check("R3", rec_n, 1'b1);
        @(negedge clk);
        check("R2", irq_n, 1'b0);
        check("R3", rec_n, 1'b0);

        // R4 full pulse length
        len = 1;
        for (int i = 0; i < 4 * N && rec_n == 1'b0; i++) begin
            @(negedge clk);
            if (rec_n == 1'b0) len++;
        end
        check_int("R4", len, N);
        // R5 single high cycle then retry
        check("R5", rec_n, 1'b1);
        @(negedge clk);
        check("R5", rec_n, 1'b0);

        // R7 fault clears early in the second pulse
        repeat (3) @(negedge clk);
        fault_n = 1'b1;
        len = 4;
        for (int i = 0; i < 4 * N && rec_n == 1'b0; i++) begin
            @(negedge clk);
            if (rec_n == 1'b0) len++;
        end
        check_int("R7", len, N);

        // R6 no further pulse
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R6", rec_n, 1'b1);
        end
        check("R6", irq_n, 1'b1);

        // R8 bypass with fault present
        bypass = 1'b1;
        fault_n = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            check("R8", rec_n, 1'b1);
        end
        check("R8", irq_n, 1'b0);

        // R9 release bypass with fault held
        bypass = 1'b0;
        @(negedge clk);
        check("R9", rec_n, 1'b0);
        repeat (5) @(negedge clk);
        bypass = 1'b1;
        @(negedge clk);
        check("R8", rec_n, 1'b1);
        bypass = 1'b0;
        fault_n = 1'b1;
        repeat (2 * N) @(negedge clk);

        // random phase, compared every cycle to the model
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 99) < 4) fault_n = ~fault_n;
            if ($urandom_range(0, 199) < 2) bypass = ~bypass;
        end
        bypass = 1'b0;
        fault_n = 1'b1;
        repeat (2 * N) @(negedge clk);

        done = 1'b1;
        report();
        $finish;
    end
endmodule